// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a two's complement integer of 8, 16 or 32 bits into a binary floating-point value. The output is either a 32-bit single precision word or a 64-bit double precision word. A caller places the operand, a size code, a precision select and the mode/status word on the inputs and pulses `start` for one cycle. One cycle later `done` pulses, and the packed result and the inexact flag are valid. They stay unchanged until the next `start`.

The datapath has three stages. The first takes the magnitude of the sign-extended operand. The second normalizes it with a leading-zero count. The third rounds and packs the fields. Rounding follows a two-bit mode that the block takes from bits 8:7 of the supplied status word. Only a 32-bit operand converted to single precision can lose bits. Every other conversion is exact.

Top module: `int2flt_conv`

## Requirements
- R1: `size_sel` 00 takes `int_op[7:0]`, 01 takes `int_op[15:0]`, and 10 or 11 takes all 32 bits. Each is sign-extended from its own top bit, and the operand bits above the selected width have no effect on the result.
- R2: With `dbl_sel`=0 the result is single precision. The sign is in bit 31, the exponent (bias 127) in bits 30:23 and the fraction in bits 22:0. `result[63:32]` is zero.
- R3: With `dbl_sel`=1 the result is double precision. The sign is in bit 63, the exponent (bias 1023) in bits 62:52 and the fraction in bits 51:0. The conversion is always exact, so `inexact` is 0.
- R4: A zero operand gives all-zero result bits (+0.0) and `inexact`=0.
- R5: The rounding mode is `status_word[8:7]`. Code 00 returns the nearest representable value, and an exact tie goes to the candidate whose fraction LSB is 0.
- R6: Code 01 truncates toward zero.
- R7: Code 10 rounds toward +infinity and code 11 rounds toward -infinity.
- R8: `inexact` is 1 exactly when the converted value differs from the integer.
- R9: After reset `done`, `result` and `inexact` are 0. `done` is high in the cycle after a `start` cycle and low otherwise. `result` and `inexact` only change in the cycle after a `start` cycle.
- R10: -2^31 converts exactly to 0xCF000000 (single) and 0xC1E0000000000000 (double).
- R11: A round-up that overflows the fraction moves into the exponent. For example, 0x7FFFFFFF in mode 00 gives 0x4F000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle conversion request |
| int_op | input | 32 | Integer operand |
| size_sel | input | 2 | Operand width code |
| dbl_sel | input | 1 | 1 selects double precision |
| status_word | input | 32 | Mode/status word; bits 8:7 give the rounding mode |
| result | output | 64 | Packed float; single precision uses bits 31:0 |
| done | output | 1 | Result valid strobe |
| inexact | output | 1 | Bits were lost in rounding |

## Verification
The bench builds the block with its default parameters: a 32-bit integer path and the standard single and double field widths. With these widths, 32-bit operands to single precision have up to eight discarded bits. That makes ties, sticky bits and fraction carries into the exponent reachable in all four rounding modes. Random operands with random size codes and junk status bits check the sign extension and the mode-field position. The double results are compared against the simulator's own real-to-bits conversion.

// File: rtl/i2f_pkg.sv
// Package: shared encodings for the integer to float converter.
// Assumes the operand width codes and rounding codes listed below.
package i2f_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rmode_e;

    localparam int RMODE_LSB = 7;
    localparam int BYTE_W    = 8;
    localparam int HALF_W    = 16;
endpackage

// File: rtl/i2f_magnitude.sv
// Module: sign-extends the selected slice of the operand and returns
// its sign and unsigned magnitude. Assumes INT_W >= 16. The magnitude
// of the most negative value wraps to 2^(INT_W-1), which is correct
// when read as unsigned.
module i2f_magnitude
    import i2f_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic [INT_W-1:0] op_i,
    input  size_e            size_i,
    output logic             sign_o,
    output logic [INT_W-1:0] mag_o
);
    logic [INT_W-1:0] ext;

    // Sign-extend from the top bit of the selected width.
    always_comb begin
        case (size_i)
            SZ_BYTE: ext = {{(INT_W-BYTE_W){op_i[BYTE_W-1]}}, op_i[BYTE_W-1:0]};
            SZ_HALF: ext = {{(INT_W-HALF_W){op_i[HALF_W-1]}}, op_i[HALF_W-1:0]};
            default: ext = op_i;
        endcase
    end

    // Absolute value in two's complement.
    always_comb begin
        sign_o = ext[INT_W-1];
        mag_o  = sign_o ? (~ext + {{(INT_W-1){1'b0}}, 1'b1}) : ext;
    end
endmodule

// File: rtl/i2f_normalize.sv
// Module: counts leading zeros and shifts the magnitude so that its
// top bit is set. For a zero magnitude it reports zero_o and the shift
// output is zero.
module i2f_normalize #(
    parameter int W   = 32,
    parameter int LZW = $clog2(W) + 1
) (
    input  logic [W-1:0]   mag_i,
    output logic [W-1:0]   norm_o,
    output logic [LZW-1:0] lz_o,
    output logic           zero_o
);
    // Leading-zero count: the highest set bit wins.
    always_comb begin
        lz_o = LZW'(W);
        for (int i = 0; i < W; i++) begin
            if (mag_i[i]) lz_o = LZW'(W - 1 - i);
        end
    end

    // Left shift by the count and flag an all-zero input.
    always_comb begin
        zero_o = (mag_i == '0);
        norm_o = mag_i << lz_o;
    end

    // R2: a nonzero magnitude always leaves here with its top bit set
    always_comb begin
        norm_msb_chk: assert (zero_o || norm_o[W-1]);
    end
endmodule

// File: rtl/i2f_round_pack.sv
// Module: builds the packed float from the normalized magnitude.
// Single precision rounds the bits below the fraction according to the
// mode. Double precision holds every integer bit exactly. Assumes
// DP_FRAC >= INT_W-1 and SP_FRAC < INT_W-2.
module i2f_round_pack
    import i2f_pkg::*;
#(
    parameter int INT_W   = 32,
    parameter int LZW     = $clog2(INT_W) + 1,
    parameter int SP_EXP  = 8,
    parameter int SP_FRAC = 23,
    parameter int DP_EXP  = 11,
    parameter int DP_FRAC = 52,
    localparam int OUT_W  = 1 + DP_EXP + DP_FRAC,
    localparam int SP_W   = 1 + SP_EXP + SP_FRAC
) (
    input  logic             sign_i,
    input  logic [INT_W-1:0] norm_i,
    input  logic [LZW-1:0]   lz_i,
    input  logic             zero_i,
    input  logic             dbl_i,
    input  rmode_e           rmode_i,
    output logic [OUT_W-1:0] result_o,
    output logic             inexact_o
);
    localparam int SP_BIAS = (1 << (SP_EXP - 1)) - 1;
    localparam int DP_BIAS = (1 << (DP_EXP - 1)) - 1;
    localparam int GRD_POS = INT_W - 2 - SP_FRAC;
    localparam int DP_PAD  = DP_FRAC - (INT_W - 1);

    logic [SP_FRAC-1:0] sp_mant;
    logic               guard, sticky, lost, round_up;
    logic [SP_FRAC:0]   mant_sum;
    logic [SP_EXP-1:0]  sp_exp;
    logic [DP_EXP-1:0]  dp_exp;

    // Split the single precision candidate into kept, guard and sticky bits.
    always_comb begin
        sp_mant = norm_i[INT_W-2 -: SP_FRAC];
        guard   = norm_i[GRD_POS];
        sticky  = |norm_i[GRD_POS-1:0];
        lost    = guard | sticky;
    end

    // Rounding decision for the four modes.
    always_comb begin
        case (rmode_i)
            RM_NEAR_EVEN: round_up = guard & (sticky | sp_mant[0]);
            RM_TO_ZERO:   round_up = 1'b0;
            RM_TO_POS:    round_up = lost & ~sign_i;
            default:      round_up = lost & sign_i;
        endcase
    end

    // Apply the increment; a carry out moves the value up one binade.
    always_comb begin
        mant_sum = {1'b0, sp_mant} + {{SP_FRAC{1'b0}}, round_up};
        sp_exp   = SP_EXP'(SP_BIAS + INT_W - 1) - SP_EXP'(lz_i)
                 + SP_EXP'(mant_sum[SP_FRAC]);
        dp_exp   = DP_EXP'(DP_BIAS + INT_W - 1) - DP_EXP'(lz_i);
    end

    // Pack the selected format; zero maps to +0.0.
    always_comb begin
        if (zero_i) begin
            result_o  = '0;
            inexact_o = 1'b0;
        end else if (dbl_i) begin
            result_o  = {sign_i, dp_exp, norm_i[INT_W-2:0], {DP_PAD{1'b0}}};
            inexact_o = 1'b0;
        end else begin
            result_o  = {{(OUT_W-SP_W){1'b0}}, sign_i, sp_exp, mant_sum[SP_FRAC-1:0]};
            inexact_o = lost;
        end
    end
endmodule

// File: rtl/int2flt_conv.sv
// Module: top of the integer to float converter. Combinational
// magnitude, normalize and round stages feed one output register stage.
// The rounding mode comes from the status word field at RMODE_LSB.
// Assumes start is a single-cycle pulse; a held start converts every cycle.
module int2flt_conv
    import i2f_pkg::*;
#(
    parameter int INT_W   = 32,
    parameter int SP_EXP  = 8,
    parameter int SP_FRAC = 23,
    parameter int DP_EXP  = 11,
    parameter int DP_FRAC = 52,
    parameter int STAT_W  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [INT_W-1:0]            int_op,
    input  logic [1:0]                  size_sel,
    input  logic                        dbl_sel,
    input  logic [STAT_W-1:0]           status_word,
    output logic [DP_EXP+DP_FRAC:0]     result,
    output logic                        done,
    output logic                        inexact
);
    localparam int LZW   = $clog2(INT_W) + 1;
    localparam int OUT_W = 1 + DP_EXP + DP_FRAC;

    logic             op_sign, op_zero, rnd_inexact;
    logic [INT_W-1:0] op_mag, op_norm;
    logic [LZW-1:0]   op_lz;
    logic [OUT_W-1:0] rnd_result;
    rmode_e           rmode;

    // Extract the rounding mode field from the status word.
    always_comb rmode = rmode_e'(status_word[RMODE_LSB+1:RMODE_LSB]);

    i2f_magnitude #(.INT_W(INT_W)) mag_u (
        .op_i   (int_op),
        .size_i (size_e'(size_sel)),
        .sign_o (op_sign),
        .mag_o  (op_mag)
    );

    i2f_normalize #(.W(INT_W), .LZW(LZW)) norm_u (
        .mag_i  (op_mag),
        .norm_o (op_norm),
        .lz_o   (op_lz),
        .zero_o (op_zero)
    );

    i2f_round_pack #(
        .INT_W(INT_W), .LZW(LZW), .SP_EXP(SP_EXP), .SP_FRAC(SP_FRAC),
        .DP_EXP(DP_EXP), .DP_FRAC(DP_FRAC)
    ) rnd_u (
        .sign_i    (op_sign),
        .norm_i    (op_norm),
        .lz_i      (op_lz),
        .zero_i    (op_zero),
        .dbl_i     (dbl_sel),
        .rmode_i   (rmode),
        .result_o  (rnd_result),
        .inexact_o (rnd_inexact)
    );

    // Output register: capture on start, pulse done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            inexact <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                result  <= rnd_result;
                inexact <= rnd_inexact;
            end
        end
    end

    // R9
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R9
    done_only_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(inexact)));

    // R3
    dbl_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dbl_sel) |=> !inexact);

    // R4
    zero_plus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_zero) |=> (result == '0 && !inexact));
endmodule

// File: tb/int2flt_conv_tb.sv
// Bench: directed corner cases plus seeded random conversions, compared
// against reference values computed by bench functions.
module int2flt_conv_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] int_op = '0;
    logic [1:0]  size_sel = '0;
    logic        dbl_sel = 1'b0;
    logic [31:0] status_word = '0;
    logic [63:0] result;
    logic        done;
    logic        inexact;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int2flt_conv dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .int_op(int_op),
        .size_sel(size_sel), .dbl_sel(dbl_sel), .status_word(status_word),
        .result(result), .done(done), .inexact(inexact)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Integer value of the selected operand slice (R1).
    function automatic longint int_value(input logic [31:0] op, input logic [1:0] sz);
        longint v;
        if (sz == 2'b00) begin
            v = longint'(op[7:0]);
            if (v >= 128) v -= 256;
        end else if (sz == 2'b01) begin
            v = longint'(op[15:0]);
            if (v >= 32768) v -= 65536;
        end else begin
            v = longint'(op);
            if (v >= 64'sd2147483648) v -= 64'sd4294967296;
        end
        return v;
    endfunction

    // Single precision reference by integer division into kept part and remainder.
    function automatic logic [32:0] ref_single(input longint v, input logic [1:0] mode);
        longint m, q, rem, half;
        int e, sh;
        logic s, lost, up;
        if (v == 0) return 33'd0;
        s = (v < 0);
        m = s ? -v : v;
        e = 0;
        while ((m >>> (e + 1)) != 0) e++;
        if (e <= 23) begin
            q = m <<< (23 - e);
            lost = 1'b0;
        end else begin
            sh   = e - 23;
            q    = m >>> sh;
            rem  = m - (q <<< sh);
            half = 64'sd1 <<< (sh - 1);
            lost = (rem != 0);
            case (mode)
                2'b00:   up = (rem > half) || (rem == half && q[0]);
                2'b01:   up = 1'b0;
                2'b10:   up = lost && !s;
                default: up = lost && s;
            endcase
            q += longint'(up);
            if (q == (64'sd1 <<< 24)) begin
                q = q >>> 1;
                e++;
            end
        end
        return {lost, s, 8'(e + 127), q[22:0]};
    endfunction

    task automatic convert(input logic [31:0] op, input logic [1:0] sz, input logic dbl,
                           input logic [1:0] mode, input string req);
        longint v;
        logic [32:0] sp;
        logic [63:0] exp_res;
        logic exp_inx;
        v = int_value(op, sz);
        if (dbl) begin
            exp_res = $realtobits(real'(v));
            exp_inx = 1'b0;
        end else begin
            sp = ref_single(v, mode);
            exp_res = {32'd0, sp[31:0]};
            exp_inx = sp[32];
        end
        @(negedge clk);
        int_op = op;
        size_sel = sz;
        dbl_sel = dbl;
        status_word = $urandom;
        status_word[8:7] = mode;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        int_op = $urandom;
        check(done === 1'b1, {req, " R9 done"}, 64'(done), 64'd1);
        check(result === exp_res, {req, " result"}, result, exp_res);
        check(inexact === exp_inx, {req, " R8 inexact"}, 64'(inexact), 64'(exp_inx));
        @(negedge clk);
        check(done === 1'b0 && result === exp_res, "R9 hold", result, exp_res);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R9 reset state
        check(done === 1'b0 && inexact === 1'b0, "R9 reset flags", 64'({done, inexact}), 64'd0);
        check(result === 64'd0, "R9 reset result", result, 64'd0);
        rst_n = 1'b1;

        convert(32'h0000_0000, 2'b10, 1'b0, 2'b00, "R4 zero single");
        convert(32'hFFFF_FF00, 2'b00, 1'b1, 2'b10, "R4 zero byte, R1 upper ignored");
        convert(32'h1234_56FF, 2'b00, 1'b0, 2'b00, "R1 byte -1");
        convert(32'hABCD_0080, 2'b00, 1'b1, 2'b00, "R1 byte -128");
        convert(32'h0000_8000, 2'b01, 1'b0, 2'b01, "R1 half -32768");
        convert(32'hFFFF_7FFF, 2'b01, 1'b1, 2'b11, "R1 half 32767");
        convert(32'h8000_0000, 2'b10, 1'b0, 2'b00, "R10 min single");
        convert(32'h8000_0000, 2'b11, 1'b1, 2'b01, "R10 min double");
        convert(32'h7FFF_FFFF, 2'b10, 1'b0, 2'b00, "R11 carry R5");
        convert(32'h7FFF_FFFF, 2'b10, 1'b0, 2'b01, "R6 toward zero");
        convert(32'h7FFF_FFFF, 2'b10, 1'b1, 2'b00, "R3 double exact");
        convert(32'h0100_0001, 2'b10, 1'b0, 2'b00, "R5 tie to even down");
        convert(32'h0100_0003, 2'b10, 1'b0, 2'b00, "R5 tie to even up");
        convert(32'h0100_0001, 2'b10, 1'b0, 2'b10, "R7 plus inf pos");
        convert(32'hFEFF_FFFF, 2'b10, 1'b0, 2'b10, "R7 plus inf neg");
        convert(32'hFEFF_FFFF, 2'b10, 1'b0, 2'b11, "R7 minus inf neg");
        convert(32'h0100_0001, 2'b10, 1'b0, 2'b11, "R7 minus inf pos");
        convert(32'h00FF_FFFF, 2'b10, 1'b0, 2'b11, "R2 exact 24 bits");

        for (int i = 0; i < 400; i++) begin
            convert($urandom, 2'($urandom), 1'($urandom), 2'($urandom), "R2 R3 random");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule